// File: doc/BRIEF.md
# Single-Bus Control Step Sequencer

This block is the hardwired controller of a processor datapath built around one shared internal bus. A step counter walks through a three-step instruction fetch and then up to three execute steps. In each step the block raises the control strobes for exactly one bus transfer: which register drives the bus, which registers capture it, what the ALU does, and whether a memory read starts. Two instruction classes are sequenced. One is a register-to-register add. The other is a load through an address held in a register.

The instruction register sits outside this block. Its opcode and three register fields arrive as inputs, and they are expected to stay steady through the execute steps. A memory-done flag lets the sequencer stall. A step that waits on memory keeps the step counter frozen, with every strobe held, until the flag is seen high. After the last step of any instruction, control returns to the first fetch step.

Top module: `step_sequencer`

## Requirements
- R1: After reset, and in every first fetch step, exactly pc_out, mar_in, mem_read, sel_const4, alu_add and z_in are high. All other strobes and both register vectors are zero.
- R2: The second fetch step raises z_out, pc_in, mdr_in_ext and wait_mem and nothing else. It repeats while mem_done is low and ends on the first edge where mem_done is high.
- R3: The third fetch step raises only mdr_out and ir_in. The first execute step follows it.
- R4: With opcode 1 (add), execute step 1 raises y_in and a one-hot gpr_out at bit ir_src1, and nothing else.
- R5: Add execute step 2 raises gpr_out at bit ir_src2, alu_add and z_in, with sel_const4 low (the Y register feeds the ALU), and nothing else.
- R6: Add execute step 3 raises z_out and a one-hot gpr_in at bit ir_dst. The next step is the first fetch step.
- R7: With opcode 2 (load), execute step 1 raises gpr_out at bit ir_src1, mar_in and mem_read, and nothing else. The field ir_src2 is ignored.
- R8: Load execute step 2 raises mdr_in_ext and wait_mem and nothing else. It holds while mem_done is low.
- R9: Load execute step 3 raises mdr_out and gpr_in at bit ir_dst. The next step is the first fetch step.
- R10: Any other opcode produces one execute step with every strobe low, followed by the first fetch step.
- R11: In every cycle at most one of pc_out, z_out, mdr_out and any gpr_out bit is high. Each register vector has at most one bit set.
- R12: While wait_mem is high and mem_done is low, every strobe keeps its value on the next cycle. In steps without wait_mem, mem_done has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset to the first fetch step |
| ir_opcode | input | OPC_W | Opcode from the instruction register |
| ir_src1 | input | RIDX_W | First source register index |
| ir_src2 | input | RIDX_W | Second source register index |
| ir_dst | input | RIDX_W | Destination register index |
| mem_done | input | 1 | Memory reports the requested operation complete |
| pc_out | output | 1 | PC drives the bus |
| pc_in | output | 1 | PC loads from the bus |
| mar_in | output | 1 | Address register loads from the bus |
| mem_read | output | 1 | Start a memory read |
| mdr_in_ext | output | 1 | Data register loads from the memory side |
| mdr_out | output | 1 | Data register drives the bus |
| ir_in | output | 1 | Instruction register loads from the bus |
| y_in | output | 1 | Y register loads from the bus |
| z_in | output | 1 | Z register loads the ALU result |
| z_out | output | 1 | Z register drives the bus |
| sel_const4 | output | 1 | ALU A input takes constant 4 instead of Y |
| alu_add | output | 1 | ALU performs addition |
| wait_mem | output | 1 | Step waits for memory completion |
| gpr_out | output | NREG | One-hot general register bus-drive enables |
| gpr_in | output | NREG | One-hot general register load enables |

## Verification
The hardest condition to reach from the ports is a long hold in a wait step with the strobes frozen, while the register fields and the flag pattern differ from the earlier steps. The bench sets a separate stall length for the fetch wait and for the load wait on each instruction, derived from the register indices. It keeps mem_done low for that many cycles and checks the full strobe vector on every held cycle. It also toggles mem_done during steps that do not wait, to show the flag is ignored there. Sweeps over every add register triple, every load source and destination pair, and every unused opcode cover the field-to-vector decoding and the return to fetch.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

   typedef enum logic [2:0] {
      ST_F1 = 3'd0,
      ST_F2 = 3'd1,
      ST_F3 = 3'd2,
      ST_E1 = 3'd3,
      ST_E2 = 3'd4,
      ST_E3 = 3'd5
   } ssq_step_e;

   typedef enum logic [1:0] {
      CLS_NOP  = 2'd0,
      CLS_ADD  = 2'd1,
      CLS_LOAD = 2'd2
   } ssq_cls_e;

   typedef struct packed {
      logic pc_out;
      logic pc_in;
      logic mar_in;
      logic mem_read;
      logic mdr_in_ext;
      logic mdr_out;
      logic ir_in;
      logic y_in;
      logic z_in;
      logic z_out;
      logic sel_const4;
      logic alu_add;
      logic wait_mem;
   } ssq_ctl_t;

endpackage

// File: rtl/ssq_opdec.sv
module ssq_opdec
   import ssq_pkg::*;
#(
   parameter int OPC_W    = 4,
   parameter int OPC_ADD  = 1,
   parameter int OPC_LOAD = 2
) (
   input  logic [OPC_W-1:0] opcode,
   output ssq_cls_e         cls
);

   always_comb begin
      if (opcode == OPC_W'(OPC_ADD))
         cls = CLS_ADD;
      else if (opcode == OPC_W'(OPC_LOAD))
         cls = CLS_LOAD;
      else
         cls = CLS_NOP;
   end

endmodule

// File: rtl/ssq_stepctr.sv
module ssq_stepctr
   import ssq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      advance,
   input  logic      restart,
   output ssq_step_e step
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         step <= ST_F1;
      else if (advance)
         step <= restart ? ST_F1 : ssq_step_e'(step + 3'd1);
   end

   AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      step <= ST_E3); // R6

   AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(step)); // R12

endmodule

// File: rtl/ssq_onehot.sv
module ssq_onehot #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [IW-1:0] idx,
   input  logic          en,
   output logic [N-1:0]  vec
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      assign vec[i] = en && (idx == IW'(i));
   end

endmodule

// File: rtl/ssq_strobe.sv
module ssq_strobe
   import ssq_pkg::*;
(
   input  ssq_step_e step,
   input  ssq_cls_e  cls,
   output ssq_ctl_t  ctl,
   output logic      gpr_drive,
   output logic      gpr_pick2,
   output logic      gpr_load,
   output logic      last
);

   always_comb begin
      ctl       = '0;
      gpr_drive = 1'b0;
      gpr_pick2 = 1'b0;
      gpr_load  = 1'b0;
      last      = 1'b0;
      unique case (step)
         ST_F1: begin
            ctl.pc_out     = 1'b1;
            ctl.mar_in     = 1'b1;
            ctl.mem_read   = 1'b1;
            ctl.sel_const4 = 1'b1;
            ctl.alu_add    = 1'b1;
            ctl.z_in       = 1'b1;
         end
         ST_F2: begin
            ctl.z_out      = 1'b1;
            ctl.pc_in      = 1'b1;
            ctl.mdr_in_ext = 1'b1;
            ctl.wait_mem   = 1'b1;
         end
         ST_F3: begin
            ctl.mdr_out = 1'b1;
            ctl.ir_in   = 1'b1;
         end
         ST_E1: begin
            case (cls)
               CLS_ADD: begin
                  gpr_drive = 1'b1;
                  ctl.y_in  = 1'b1;
               end
               CLS_LOAD: begin
                  gpr_drive    = 1'b1;
                  ctl.mar_in   = 1'b1;
                  ctl.mem_read = 1'b1;
               end
               default: last = 1'b1;
            endcase
         end
         ST_E2: begin
            case (cls)
               CLS_ADD: begin
                  gpr_drive   = 1'b1;
                  gpr_pick2   = 1'b1;
                  ctl.alu_add = 1'b1;
                  ctl.z_in    = 1'b1;
               end
               CLS_LOAD: begin
                  ctl.mdr_in_ext = 1'b1;
                  ctl.wait_mem   = 1'b1;
               end
               default: last = 1'b1;
            endcase
         end
         ST_E3: begin
            last = 1'b1;
            case (cls)
               CLS_ADD: begin
                  ctl.z_out = 1'b1;
                  gpr_load  = 1'b1;
               end
               CLS_LOAD: begin
                  ctl.mdr_out = 1'b1;
                  gpr_load    = 1'b1;
               end
               default: ;
            endcase
         end
         default: last = 1'b1;
      endcase
   end

endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
   import ssq_pkg::*;
#(
   parameter  int NREG     = 8,
   parameter  int OPC_W    = 4,
   parameter  int OPC_ADD  = 1,
   parameter  int OPC_LOAD = 2,
   localparam int RIDX_W   = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OPC_W-1:0]  ir_opcode,
   input  logic [RIDX_W-1:0] ir_src1,
   input  logic [RIDX_W-1:0] ir_src2,
   input  logic [RIDX_W-1:0] ir_dst,
   input  logic              mem_done,
   output logic              pc_out,
   output logic              pc_in,
   output logic              mar_in,
   output logic              mem_read,
   output logic              mdr_in_ext,
   output logic              mdr_out,
   output logic              ir_in,
   output logic              y_in,
   output logic              z_in,
   output logic              z_out,
   output logic              sel_const4,
   output logic              alu_add,
   output logic              wait_mem,
   output logic [NREG-1:0]   gpr_out,
   output logic [NREG-1:0]   gpr_in
);

   if (NREG < 2) begin : g_bad_nreg
      $error("step_sequencer: NREG must be at least 2");
   end
   if (OPC_ADD == OPC_LOAD) begin : g_bad_opc
      $error("step_sequencer: add and load opcodes must differ");
   end
   if (OPC_ADD >= (1 << OPC_W) || OPC_LOAD >= (1 << OPC_W)) begin : g_bad_opw
      $error("step_sequencer: opcode value does not fit OPC_W");
   end

   ssq_step_e         step;
   ssq_cls_e          cls;
   ssq_ctl_t          ctl;
   logic              gpr_drive, gpr_pick2, gpr_load, last;
   logic              advance;
   logic [RIDX_W-1:0] drive_idx;

   ssq_opdec #(.OPC_W(OPC_W), .OPC_ADD(OPC_ADD), .OPC_LOAD(OPC_LOAD)) u_dec (
      .opcode (ir_opcode),
      .cls    (cls)
   );

   ssq_strobe u_strb (
      .step      (step),
      .cls       (cls),
      .ctl       (ctl),
      .gpr_drive (gpr_drive),
      .gpr_pick2 (gpr_pick2),
      .gpr_load  (gpr_load),
      .last      (last)
   );

   assign advance = !(ctl.wait_mem && !mem_done);

   ssq_stepctr u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (advance),
      .restart (last),
      .step    (step)
   );

   assign drive_idx = gpr_pick2 ? ir_src2 : ir_src1;

   ssq_onehot #(.N(NREG), .IW(RIDX_W)) u_oh_out (
      .idx (drive_idx),
      .en  (gpr_drive),
      .vec (gpr_out)
   );

   ssq_onehot #(.N(NREG), .IW(RIDX_W)) u_oh_in (
      .idx (ir_dst),
      .en  (gpr_load),
      .vec (gpr_in)
   );

   assign pc_out     = ctl.pc_out;
   assign pc_in      = ctl.pc_in;
   assign mar_in     = ctl.mar_in;
   assign mem_read   = ctl.mem_read;
   assign mdr_in_ext = ctl.mdr_in_ext;
   assign mdr_out    = ctl.mdr_out;
   assign ir_in      = ctl.ir_in;
   assign y_in       = ctl.y_in;
   assign z_in       = ctl.z_in;
   assign z_out      = ctl.z_out;
   assign sel_const4 = ctl.sel_const4;
   assign alu_add    = ctl.alu_add;
   assign wait_mem   = ctl.wait_mem;

   AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({pc_out, z_out, mdr_out, |gpr_out}) <= 1); // R11

   AST_GPR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gpr_out) && $onehot0(gpr_in)); // R11

   AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_mem && !mem_done) |=> $stable({ctl, gpr_out, gpr_in})); // R12

   AST_IR_AFTER_PC: assert property (@(posedge clk) disable iff (!rst_n)
      ir_in |-> $past(pc_in && mem_done)); // R3

   AST_DST_FROM_MDR: assert property (@(posedge clk) disable iff (!rst_n)
      (mdr_out && |gpr_in) |-> $past(mdr_in_ext && mem_done)); // R9

   AST_ADD_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (z_out && |gpr_in) |=> (pc_out && mar_in && sel_const4)); // R6

endmodule

// File: tb/sim_step_sequencer.sv
`timescale 1ns/1ps
module sim_step_sequencer;

   localparam int NR = 8;

   localparam logic [12:0] B_PC_OUT = 13'h1000;
   localparam logic [12:0] B_PC_IN  = 13'h0800;
   localparam logic [12:0] B_MAR_IN = 13'h0400;
   localparam logic [12:0] B_READ   = 13'h0200;
   localparam logic [12:0] B_MDR_IE = 13'h0100;
   localparam logic [12:0] B_MDR_O  = 13'h0080;
   localparam logic [12:0] B_IR_IN  = 13'h0040;
   localparam logic [12:0] B_Y_IN   = 13'h0020;
   localparam logic [12:0] B_Z_IN   = 13'h0010;
   localparam logic [12:0] B_Z_OUT  = 13'h0008;
   localparam logic [12:0] B_C4     = 13'h0004;
   localparam logic [12:0] B_ADD    = 13'h0002;
   localparam logic [12:0] B_WAIT   = 13'h0001;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    opc = '0;
   logic [2:0]    s1 = '0, s2 = '0, dd = '0;
   logic          mem_done = 1'b1;
   logic          pc_out, pc_in, mar_in, mem_read, mdr_in_ext, mdr_out, ir_in;
   logic          y_in, z_in, z_out, sel_const4, alu_add, wait_mem;
   logic [NR-1:0] gpr_out, gpr_in;
   logic [28:0]   act;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   step_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .ir_opcode(opc), .ir_src1(s1), .ir_src2(s2),
      .ir_dst(dd), .mem_done(mem_done), .pc_out(pc_out), .pc_in(pc_in),
      .mar_in(mar_in), .mem_read(mem_read), .mdr_in_ext(mdr_in_ext),
      .mdr_out(mdr_out), .ir_in(ir_in), .y_in(y_in), .z_in(z_in),
      .z_out(z_out), .sel_const4(sel_const4), .alu_add(alu_add),
      .wait_mem(wait_mem), .gpr_out(gpr_out), .gpr_in(gpr_in)
   );

   assign act = {pc_out, pc_in, mar_in, mem_read, mdr_in_ext, mdr_out, ir_in,
                 y_in, z_in, z_out, sel_const4, alu_add, wait_mem, gpr_out, gpr_in};

   function automatic logic [28:0] mk(logic [12:0] c, logic [NR-1:0] go, logic [NR-1:0] gi);
      return {c, go, gi};
   endfunction

   function automatic logic [NR-1:0] oh(logic [2:0] i);
      return NR'(1) << i;
   endfunction

   task automatic check(string tag, logic [28:0] e);
      n_chk++;
      if (act !== e) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, e);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   localparam logic [12:0] C_F1 = B_PC_OUT | B_MAR_IN | B_READ | B_C4 | B_ADD | B_Z_IN;
   localparam logic [12:0] C_F2 = B_Z_OUT | B_PC_IN | B_MDR_IE | B_WAIT;
   localparam logic [12:0] C_F3 = B_MDR_O | B_IR_IN;

   // one full instruction: fetch with fs stall cycles, execute with ls stall cycles
   task automatic run(logic [3:0] o, logic [2:0] a, logic [2:0] b, logic [2:0] d,
                      int fs, int ls, logic noise);
      opc = o; s1 = a; s2 = b; dd = d;
      mem_done = noise;
      check("R1 fetch step 1", mk(C_F1, '0, '0));
      tick();
      for (int k = 0; k < fs; k++) begin
         mem_done = 1'b0;
         check("R2/R12 fetch wait held", mk(C_F2, '0, '0));
         tick();
      end
      mem_done = 1'b1;
      check("R2 fetch step 2", mk(C_F2, '0, '0));
      tick();
      mem_done = ~noise;
      check("R3 fetch step 3", mk(C_F3, '0, '0));
      tick();
      if (o == 4'd1) begin
         check("R4 add step 1", mk(B_Y_IN, oh(a), '0));
         tick();
         mem_done = noise;
         check("R5/R11 add step 2", mk(B_ADD | B_Z_IN, oh(b), '0));
         tick();
         check("R6 add step 3", mk(B_Z_OUT, '0, oh(d)));
         tick();
      end else if (o == 4'd2) begin
         check("R7 load step 1", mk(B_MAR_IN | B_READ, oh(a), '0));
         tick();
         for (int k = 0; k < ls; k++) begin
            mem_done = 1'b0;
            check("R8/R12 load wait held", mk(B_MDR_IE | B_WAIT, '0, '0));
            tick();
         end
         mem_done = 1'b1;
         check("R8 load step 2", mk(B_MDR_IE | B_WAIT, '0, '0));
         tick();
         mem_done = noise;
         check("R9 load step 3", mk(B_MDR_O, '0, oh(d)));
         tick();
      end else begin
         check("R10 unknown opcode idle step", mk('0, '0, '0));
         tick();
      end
   endtask

   initial begin
      repeat (3) tick();
      check("R1 state during reset", mk(C_F1, '0, '0));
      rst_n = 1'b1;
      check("R1 state after reset", mk(C_F1, '0, '0));
      for (int a = 0; a < NR; a++)
         for (int b = 0; b < NR; b++)
            for (int d = 0; d < NR; d++)
               run(4'd1, 3'(a), 3'(b), 3'(d), (a + d) % 3, 0, 1'((a ^ b) & 1));
      for (int a = 0; a < NR; a++)
         for (int d = 0; d < NR; d++)
            run(4'd2, 3'(a), 3'((a * 3 + 5) % NR), 3'(d), d % 2, (a + d) % 5, 1'(d & 1));
      for (int o = 0; o < 16; o++)
         if (o != 1 && o != 2)
            run(4'(o), 3'd7, 3'd3, 3'd5, o % 2, 0, 1'(o & 1));
      check("R6/R10 back to fetch step 1", mk(C_F1, '0, '0));
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule